// File: doc/BRIEF.md
# Power Converter Fault Supervisor

This block watches a dual-channel switching regulator and an auxiliary linear regulator and decides, one converter clock at a time, whether the gate drivers may follow the PWM commands. It takes single-bit comparator results for each switching channel: overcurrent, overvoltage and undervoltage. It also takes an undervoltage flag for the linear regulator, an over-temperature flag whose hysteresis lives in the external comparator, and an enable pin. From these it drives per-channel high-side and low-side gate enables, a sticky fault flag, an overall run signal and a one-cycle restart request for the soft-start logic.

Overcurrent is not acted on at once. A per-channel counter has to see the condition on a fixed number of consecutive clocks before the fault latch is set. Overvoltage acts in the same cycle as a crowbar. It turns the low-side switch of that channel on for as long as the comparator stays high, and it never latches. The enable and temperature pins are asynchronous and pass through a synchronizer first. A rising edge of the synchronized enable is the only thing that clears a latched fault.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: While the synchronized enable is low, every `hs_en` and `ls_en` bit is 0 and `run` is 0, whatever the PWM and comparator inputs are.
- R2: When `oc_sw[i]` is high on OC_CONFIRM (default 8) consecutive rising clock edges while `run` is high, `fault_latched` goes to 1 at the last of those edges and `run` drops. With one fewer edge, no fault is latched.
- R3: If `oc_sw[i]` is low on any sampled edge, that channel's overcurrent count restarts from zero, so the next event needs a full OC_CONFIRM window.
- R4: While `run` is high, `ls_en[i] = pwm_lo[i] | ov_sw[i]` and `hs_en[i] = pwm_hi[i] & ~ov_sw[i]`. The crowbar is released in the same cycle that `ov_sw[i]` falls.
- R5: Overvoltage on its own never sets `fault_latched`.
- R6: Any of `uv_sw[i]` or `uv_ldo` high on a rising edge while `run` is high sets `fault_latched` at that edge.
- R7: While `fault_latched` is 1, `run` is 0 and all gate enables are 0, even with overvoltage asserted.
- R8: `fault_latched` stays set while enable is low. It clears at the edge after the synchronized enable rises.
- R9: While the synchronized over-temperature flag is high, `run` and all gate enables are 0. Operation resumes when the flag falls, and no fault is latched.
- R10: `ss_restart` is high for exactly the first cycle in which `run` is high after a cycle in which it was low.
- R11: `en_pin` and `ot_flag` take effect SYNC_STAGES (default 2) rising edges after they change.
- R12: After reset `run`, `fault_latched`, `ss_restart` and all gate enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_pin | input | 1 | Asynchronous enable pin |
| ot_flag | input | 1 | Asynchronous over-temperature flag, hysteresis applied externally |
| oc_sw | input | NUM_CH | Overcurrent comparator per switching channel |
| ov_sw | input | NUM_CH | Overvoltage comparator per switching channel |
| uv_sw | input | NUM_CH | Undervoltage comparator per switching channel |
| uv_ldo | input | 1 | Linear regulator undervoltage (from its current limit) |
| pwm_hi | input | NUM_CH | PWM high-side command |
| pwm_lo | input | NUM_CH | PWM low-side command |
| hs_en | output | NUM_CH | High-side gate enable |
| ls_en | output | NUM_CH | Low-side gate enable |
| fault_latched | output | 1 | Sticky fault flag |
| run | output | 1 | Converter may operate |
| ss_restart | output | 1 | One-cycle soft-start restart request |

## Verification
The hardest case to reach is the boundary of the overcurrent window. The bench holds overcurrent for exactly one edge fewer than the window and shows that nothing latches. It then interrupts a nearly complete window with a single low sample and shows that the count restarts. Only after that does it hold the condition for the full window and check that the latch sets at that exact edge. A second hard point is a latched fault with overvoltage present. The bench latches a fault first and then drives overvoltage, to show that the latch overrides the crowbar. It then clears the latch only through a disable and re-enable sequence and checks the synchronizer latency along the way.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   // width of a counter that holds values 0 .. n-1
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pfs_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pfs_oc_filter.sv
module pfs_oc_filter #(
   parameter int unsigned CONFIRM = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic oc_in,
   output logic trip
);
   localparam int unsigned CNT_W = pfs_pkg::cnt_width(CONFIRM);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CONFIRM - 1);

   if (CONFIRM < 2) begin : g_bad_confirm
      $error("pfs_oc_filter: CONFIRM must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic             armed_oc;

   assign armed_oc = arm & oc_in;
   assign trip     = armed_oc & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!armed_oc || trip) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
   end

   // R3
   oc_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> $past(oc_in));
endmodule

// File: rtl/pfs_fault_ctl.sv
module pfs_fault_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic en_s,
   input  logic ot_s,
   input  logic trip_any,
   input  logic uv_any,
   output logic fault_q,
   output logic run,
   output logic restart
);
   logic en_d;
   logic en_rise;
   logic run_d;

   assign en_rise = en_s & ~en_d;
   assign run     = en_s & ~ot_s & ~fault_q;
   assign restart = run & ~run_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d    <= 1'b0;
         run_d   <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         en_d  <= en_s;
         run_d <= run;
         if (en_rise)                         fault_q <= 1'b0;
         else if (run && (trip_any || uv_any)) fault_q <= 1'b1;
      end
   end

   // R8
   fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_rise |=> !fault_q);
   // R8
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q && !en_rise) |=> fault_q);
   // R10
   restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !restart);
endmodule

// File: rtl/pwr_fault_supervisor.sv
module pwr_fault_supervisor #(
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned OC_CONFIRM  = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_pin,
   input  logic              ot_flag,
   input  logic [NUM_CH-1:0] oc_sw,
   input  logic [NUM_CH-1:0] ov_sw,
   input  logic [NUM_CH-1:0] uv_sw,
   input  logic              uv_ldo,
   input  logic [NUM_CH-1:0] pwm_hi,
   input  logic [NUM_CH-1:0] pwm_lo,
   output logic [NUM_CH-1:0] hs_en,
   output logic [NUM_CH-1:0] ls_en,
   output logic              fault_latched,
   output logic              run,
   output logic              ss_restart
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("pwr_fault_supervisor: NUM_CH must be at least 1");
   end

   logic [1:0]        sync_q;
   logic              en_s;
   logic              ot_s;
   logic [NUM_CH-1:0] trip;

   pfs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ot_flag, en_pin}),
      .q     (sync_q)
   );
   assign en_s = sync_q[0];
   assign ot_s = sync_q[1];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      pfs_oc_filter #(.CONFIRM(OC_CONFIRM)) u_oc (
         .clk   (clk),
         .rst_n (rst_n),
         .arm   (run),
         .oc_in (oc_sw[i]),
         .trip  (trip[i])
      );

      // crowbar outranks PWM; run gating outranks crowbar
      assign hs_en[i] = run & pwm_hi[i] & ~ov_sw[i];
      assign ls_en[i] = run & (pwm_lo[i] | ov_sw[i]);

      // R4
      crowbar_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (run && ov_sw[i]) |-> (ls_en[i] && !hs_en[i]));
   end

   pfs_fault_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_s     (en_s),
      .ot_s     (ot_s),
      .trip_any (|trip),
      .uv_any   ((|uv_sw) | uv_ldo),
      .fault_q  (fault_latched),
      .run      (run),
      .restart  (ss_restart)
   );

   // R1
   gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> ((hs_en == '0) && (ls_en == '0)));
   // R7
   fault_blocks_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_latched |-> !run);
endmodule

// File: tb/pwr_fault_supervisor_bench.sv
module pwr_fault_supervisor_bench;
   localparam int NCH = 2;
   localparam int OCN = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           en_pin = 1'b0;
   logic           ot_flag = 1'b0;
   logic [NCH-1:0] oc_sw = '0, ov_sw = '0, uv_sw = '0;
   logic           uv_ldo = 1'b0;
   logic [NCH-1:0] pwm_hi = '0, pwm_lo = '0;
   logic [NCH-1:0] hs_en, ls_en;
   logic           fault_latched, run, ss_restart;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwr_fault_supervisor #(.NUM_CH(NCH), .OC_CONFIRM(OCN), .SYNC_STAGES(2)) u_pwr_fault_supervisor (
      .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .ot_flag(ot_flag),
      .oc_sw(oc_sw), .ov_sw(ov_sw), .uv_sw(uv_sw), .uv_ldo(uv_ldo),
      .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .hs_en(hs_en), .ls_en(ls_en),
      .fault_latched(fault_latched), .run(run), .ss_restart(ss_restart)
   );

   // {pwm_hi, pwm_lo, ov_sw, expected hs_en, expected ls_en}
   localparam logic [9:0] VEC [8] = '{
      {2'b01, 2'b10, 2'b00, 2'b01, 2'b10},
      {2'b10, 2'b01, 2'b00, 2'b10, 2'b01},
      {2'b11, 2'b00, 2'b01, 2'b10, 2'b01},
      {2'b11, 2'b00, 2'b10, 2'b01, 2'b10},
      {2'b00, 2'b00, 2'b11, 2'b00, 2'b11},
      {2'b01, 2'b10, 2'b01, 2'b00, 2'b11},
      {2'b11, 2'b11, 2'b00, 2'b11, 2'b11},
      {2'b00, 2'b00, 2'b00, 2'b00, 2'b00}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic reenable();
      en_pin = 1'b0;
      step(3);
      en_pin = 1'b1;
      step(3);
   endtask

   initial begin
      #(5ns * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R12 reset state
      chk(run == 0 && fault_latched == 0 && ss_restart == 0, "R12", {run, fault_latched, ss_restart}, 0);
      chk(hs_en == 0 && ls_en == 0, "R12", {hs_en, ls_en}, 0);

      // R1 disabled: gates stay off
      pwm_hi = 2'b11; pwm_lo = 2'b11; ov_sw = 2'b11;
      step(1);
      chk(hs_en == 0 && ls_en == 0, "R1", {hs_en, ls_en}, 0);
      pwm_hi = '0; pwm_lo = '0; ov_sw = '0;

      // R11 enable latency, R10 restart pulse
      en_pin = 1'b1;
      step(1);
      chk(run == 0, "R11", run, 0);
      step(1);
      chk(run == 1, "R11", run, 1);
      chk(ss_restart == 1, "R10", ss_restart, 1);
      step(1);
      chk(ss_restart == 0, "R10", ss_restart, 0);

      // R4 / R5 gate table
      foreach (VEC[v]) begin
         pwm_hi = VEC[v][9:8]; pwm_lo = VEC[v][7:6]; ov_sw = VEC[v][5:4];
         #1;
         chk(hs_en == VEC[v][3:2], "R4 hs", hs_en, VEC[v][3:2]);
         chk(ls_en == VEC[v][1:0], "R4 ls", ls_en, VEC[v][1:0]);
         step(1);
         chk(fault_latched == 0, "R5", fault_latched, 0);
      end
      ov_sw = 2'b01; pwm_lo = 2'b00; #1;
      ov_sw = 2'b00; #1;
      chk(ls_en == 0, "R4 release", ls_en, 0);

      // R2 one edge short of the window
      oc_sw[0] = 1'b1;
      step(OCN - 1);
      oc_sw[0] = 1'b0;
      step(1);
      chk(fault_latched == 0, "R2 short", fault_latched, 0);

      // R3 dropout restarts count
      oc_sw[1] = 1'b1; step(OCN - 1);
      oc_sw[1] = 1'b0; step(1);
      oc_sw[1] = 1'b1; step(OCN - 1);
      chk(fault_latched == 0, "R3", fault_latched, 0);
      step(1);
      chk(fault_latched == 1, "R2 full", fault_latched, 1);
      chk(run == 0, "R2 run", run, 0);
      oc_sw = '0;

      // R7 latch beats crowbar
      pwm_hi = 2'b11; ov_sw = 2'b11;
      step(1);
      chk(hs_en == 0 && ls_en == 0, "R7", {hs_en, ls_en}, 0);
      ov_sw = '0;

      // R8 held while disabled, cleared after rising edge
      en_pin = 1'b0; step(3);
      chk(fault_latched == 1, "R8 hold", fault_latched, 1);
      en_pin = 1'b1; step(2);
      chk(fault_latched == 1, "R8 pre", fault_latched, 1);
      step(1);
      chk(fault_latched == 0, "R8 clear", fault_latched, 0);
      chk(run == 1 && ss_restart == 1, "R10 after clear", {run, ss_restart}, 3);
      pwm_hi = '0;

      // R6 undervoltage sources
      uv_sw[1] = 1'b1; step(1); uv_sw = '0;
      chk(fault_latched == 1, "R6 sw", fault_latched, 1);
      reenable();
      chk(fault_latched == 0, "R6 clr", fault_latched, 0);
      uv_ldo = 1'b1; step(1); uv_ldo = 1'b0;
      chk(fault_latched == 1, "R6 ldo", fault_latched, 1);
      reenable();

      // R9 over-temperature
      pwm_hi = 2'b11;
      ot_flag = 1'b1; step(1);
      chk(run == 1, "R11 ot", run, 1);
      step(1);
      chk(run == 0 && hs_en == 0, "R9 off", {run, hs_en}, 0);
      ot_flag = 1'b0; step(2);
      chk(run == 1 && ss_restart == 1, "R9 resume", {run, ss_restart}, 3);
      chk(fault_latched == 0, "R9 nolatch", fault_latched, 0);

      // R1 disable while running
      en_pin = 1'b0; step(2);
      chk(hs_en == 0 && run == 0, "R1 drop", {run, hs_en}, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule